// File: doc/BRIEF.md
# CAN Bus Wake-Up Pattern Detector

This block watches the sampled output of a low-power bus receiver while a transceiver sits in its standby state. It recognizes the wake-up sequence of a dominant phase, then a recessive phase, then a second dominant phase, each at least a minimum length. It raises a sticky wake flag that the host reads to leave standby. All times are counted in clock cycles and are set by parameters.

A glitch filter sits in front of the sequencer. A bus level has to hold for the filter width before the filtered level follows it, so short spikes neither end a phase nor start one. The filtered level is also brought out of the block. The whole sequence has to finish inside a completion window that starts with the first dominant phase. A window that runs out, an abort event (supply undervoltage or a change of operating mode, collected outside the block) or the loss of the standby qualifier throws away a partly received pattern. A bus held dominant continuously therefore never wakes the node.

Top module: `canwake_detect`

## Requirements
- R1: `wake_flag` goes high when the filtered bus shows, in order, at least PHASE_MIN cycles dominant, at least PHASE_MIN cycles recessive, and PHASE_MIN cycles dominant. It rises on the clock edge that samples the PHASE_MIN-th cycle of the second dominant phase. The bus encoding is 1 = dominant and 0 = recessive.
- R2: `filt_dom` follows `bus_dom` only after the new level has been sampled on FILT_LEN consecutive edges. A level held for fewer edges is ignored. A level held for N >= FILT_LEN edges shows on `filt_dom` for exactly N sampled cycles.
- R3: A first dominant phase or a second dominant phase shorter than PHASE_MIN cycles discards the pattern. A recessive phase shorter than PHASE_MIN cycles makes the dominant phase that follows it count as a new first phase.
- R4: The completion window counts cycles from the clock edge that enters the first dominant phase. It saturates at WINDOW_LEN. When it reaches WINDOW_LEN with the pattern unfinished, the detector returns to idle on that same edge, and the timeout takes priority over completion.
- R5: `abort_evt` high discards any partly received pattern and blocks the start of a new one for that cycle.
- R6: While `stby_en` is low, no pattern is tracked and any partial pattern is discarded.
- R7: A bus that stays dominant with no recessive phase never sets `wake_flag`.
- R8: Once set, `wake_flag` stays high through any bus activity and abort events until `stby_en` is low, and it reads low on the cycle after the edge that samples `stby_en` low.
- R9: After reset, `wake_flag` and `filt_dom` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stby_en | input | 1 | High while the device is in standby; enables detection and holds the flag |
| bus_dom | input | 1 | Raw receiver sample, 1 = dominant |
| abort_evt | input | 1 | Undervoltage or mode-change event that discards a partial pattern |
| filt_dom | output | 1 | Glitch-filtered bus level, 1 = dominant |
| wake_flag | output | 1 | Sticky wake-up indication |

## Verification
The bench drives phases exactly at PHASE_MIN and one cycle short of it. A design that compared with the wrong sign would wake on a short phase or miss a legal one. It sends a short recessive gap followed by a full pattern, which fails if the design drops to idle and clips one cycle off the next dominant phase. It places completion one cycle before and exactly at the window limit, catching an off-by-one timer or a timeout that loses to completion. Spikes one cycle under the filter width, a bus held dominant past several windows, and aborts or loss of standby in mid-pattern each target a design that would react to noise, wake on a clamped bus or resume a stale pattern.

// File: rtl/canwake_pkg.sv
package canwake_pkg;
   typedef enum logic [2:0] {
      CW_IDLE = 3'd0,
      CW_DOM1 = 3'd1,
      CW_REC  = 3'd2,
      CW_DOM2 = 3'd3,
      CW_WOKE = 3'd4
   } cw_state_e;
endpackage

// File: rtl/canwake_filt.sv
module canwake_filt #(
   parameter int FILT_LEN = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);
   generate
      if (FILT_LEN <= 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt_o <= 1'b0;
            else        filt_o <= raw_i;
         end
      end else begin : g_count
         localparam int CW = $clog2(FILT_LEN);
         localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);
         logic [CW-1:0] diff_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt_o   <= 1'b0;
               diff_cnt <= '0;
            end else if (raw_i != filt_o) begin
               if (diff_cnt == LAST) begin
                  filt_o   <= raw_i;
                  diff_cnt <= '0;
               end else begin
                  diff_cnt <= diff_cnt + 1'b1;
               end
            end else begin
               diff_cnt <= '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/canwake_win.sv
module canwake_win #(
   parameter int WINDOW_LEN = 50000,
   localparam int WW = $clog2(WINDOW_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart_i,
   input  logic          run_i,
   output logic          tmo_o,
   output logic [WW-1:0] cnt_o
);
   localparam logic [WW-1:0] LIMIT = WW'(WINDOW_LEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_o <= '0;
      else if (restart_i)              cnt_o <= WW'(1);
      else if (!run_i)                 cnt_o <= '0;
      else if (cnt_o != LIMIT)         cnt_o <= cnt_o + 1'b1;
   end

   assign tmo_o = run_i && (cnt_o == LIMIT);
endmodule

// File: rtl/canwake_seq.sv
module canwake_seq
   import canwake_pkg::*;
#(
   parameter int PHASE_MIN = 25
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      filt_dom,
   input  logic      stby_en,
   input  logic      abort_evt,
   input  logic      tmo,
   output cw_state_e state,
   output logic      win_restart,
   output logic      win_run
);
   localparam int RW = $clog2(PHASE_MIN + 1);
   localparam logic [RW-1:0] PMIN  = RW'(PHASE_MIN);
   localparam logic [RW-1:0] PMIN1 = RW'(PHASE_MIN - 1);

   cw_state_e     nxt;
   logic [RW-1:0] run_len, run_nxt, run_inc;

   assign run_inc = (run_len == PMIN) ? run_len : run_len + 1'b1;
   assign win_run = (state == CW_DOM1) || (state == CW_REC) || (state == CW_DOM2);

   always_comb begin
      nxt         = state;
      run_nxt     = run_len;
      win_restart = 1'b0;
      unique case (state)
         CW_IDLE: begin
            if (stby_en && !abort_evt && filt_dom) begin
               nxt         = CW_DOM1;
               run_nxt     = RW'(1);
               win_restart = 1'b1;
            end
         end
         CW_DOM1: begin
            if (filt_dom)             run_nxt = run_inc;
            else if (run_len >= PMIN) begin
               nxt     = CW_REC;
               run_nxt = RW'(1);
            end else                  nxt = CW_IDLE;
         end
         CW_REC: begin
            if (!filt_dom)            run_nxt = run_inc;
            else if (run_len >= PMIN) begin
               nxt     = CW_DOM2;
               run_nxt = RW'(1);
            end else begin
               nxt         = CW_DOM1;
               run_nxt     = RW'(1);
               win_restart = 1'b1;
            end
         end
         CW_DOM2: begin
            if (!filt_dom)              nxt = CW_IDLE;
            else if (run_len >= PMIN1)  nxt = CW_WOKE;
            else                        run_nxt = run_inc;
         end
         CW_WOKE: ;
         default: nxt = CW_IDLE;
      endcase
      if (!stby_en) begin
         nxt         = CW_IDLE;
         win_restart = 1'b0;
      end else if ((state != CW_WOKE) && (abort_evt || tmo)) begin
         nxt         = CW_IDLE;
         win_restart = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= CW_IDLE;
         run_len <= '0;
      end else begin
         state   <= nxt;
         run_len <= run_nxt;
      end
   end
endmodule

// File: rtl/canwake_detect.sv
module canwake_detect
   import canwake_pkg::*;
#(
   parameter int PHASE_MIN  = 25,
   parameter int FILT_LEN   = 25,
   parameter int WINDOW_LEN = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stby_en,
   input  logic bus_dom,
   input  logic abort_evt,
   output logic filt_dom,
   output logic wake_flag
);
   localparam int WW = $clog2(WINDOW_LEN + 1);

   generate
      if (PHASE_MIN < 2) begin : g_bad_phase
         $error("canwake_detect: PHASE_MIN must be at least 2");
      end
      if (FILT_LEN > PHASE_MIN) begin : g_bad_filt
         $error("canwake_detect: FILT_LEN must not exceed PHASE_MIN");
      end
      if (WINDOW_LEN <= 3 * PHASE_MIN) begin : g_bad_win
         $error("canwake_detect: WINDOW_LEN must exceed three phases");
      end
   endgenerate

   cw_state_e     state;
   logic          win_restart, win_run, tmo;
   logic [WW-1:0] win_cnt;

   canwake_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(bus_dom), .filt_o(filt_dom)
   );

   canwake_seq #(.PHASE_MIN(PHASE_MIN)) u_seq (
      .clk(clk), .rst_n(rst_n), .filt_dom(filt_dom), .stby_en(stby_en),
      .abort_evt(abort_evt), .tmo(tmo), .state(state),
      .win_restart(win_restart), .win_run(win_run)
   );

   canwake_win #(.WINDOW_LEN(WINDOW_LEN)) u_win (
      .clk(clk), .rst_n(rst_n), .restart_i(win_restart), .run_i(win_run),
      .tmo_o(tmo), .cnt_o(win_cnt)
   );

   assign wake_flag = (state == CW_WOKE);
endmodule

// File: rtl/canwake_detect_chk.sv
module canwake_detect_chk
   import canwake_pkg::*;
#(
   parameter int WINDOW_LEN = 50000,
   localparam int WW = $clog2(WINDOW_LEN + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          stby_en,
   input logic          bus_dom,
   input logic          abort_evt,
   input logic          filt_dom,
   input logic          wake_flag,
   input cw_state_e     state,
   input logic          tmo,
   input logic [WW-1:0] win_cnt
);
   a_r1_wake_after_dom2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag) |-> ($past(state) == CW_DOM2) && $past(filt_dom));

   a_r2_filter_moves_to_raw: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt_dom) |-> ($past(bus_dom) == filt_dom));

   a_r4_timeout_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> (state == CW_IDLE));

   a_r4_window_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      win_cnt <= WW'(WINDOW_LEN));

   a_r5_abort_discards: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_evt && (state != CW_WOKE)) |=> (state == CW_IDLE));

   a_r6_standby_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !stby_en |=> (state == CW_IDLE) && !wake_flag);

   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_flag && stby_en) |=> wake_flag);
endmodule

bind canwake_detect canwake_detect_chk #(.WINDOW_LEN(WINDOW_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .stby_en(stby_en), .bus_dom(bus_dom),
   .abort_evt(abort_evt), .filt_dom(filt_dom), .wake_flag(wake_flag),
   .state(state), .tmo(tmo), .win_cnt(win_cnt)
);

// File: tb/canwake_detect_bench.sv
module canwake_detect_bench;
   localparam int PM  = 10;
   localparam int FL  = 4;
   localparam int WIN = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stby_en = 1'b0;
   logic bus_dom = 1'b0;
   logic abort_evt = 1'b0;
   logic filt_dom, wake_flag;
   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   canwake_detect #(.PHASE_MIN(PM), .FILT_LEN(FL), .WINDOW_LEN(WIN)) u_canwake_detect (
      .clk(clk), .rst_n(rst_n), .stby_en(stby_en), .bus_dom(bus_dom),
      .abort_evt(abort_evt), .filt_dom(filt_dom), .wake_flag(wake_flag)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic hold(input logic lvl, input int n);
      bus_dom = lvl;
      repeat (n) @(negedge clk);
   endtask

   task automatic clean_start();
      stby_en = 1'b0; abort_evt = 1'b0;
      hold(1'b0, 20);
      stby_en = 1'b1;
      hold(1'b0, 5);
   endtask

   task automatic pattern(input int d1, input int r, input int d2);
      hold(1'b1, d1);
      hold(1'b0, r);
      hold(1'b1, d2);
      hold(1'b0, 20);
   endtask

   task automatic t_reset();
      check("R9 wake after reset", wake_flag, 0);
      check("R9 filt after reset", filt_dom, 0);
   endtask

   task automatic t_filter();
      int hi = 0;
      clean_start();
      bus_dom = 1'b1;
      repeat (FL - 1) begin @(negedge clk); hi += filt_dom; end
      bus_dom = 1'b0;
      repeat (10) begin @(negedge clk); hi += filt_dom; end
      check("R2 spike below filter width", hi, 0);
      hi = 0;
      bus_dom = 1'b1;
      repeat (FL) begin @(negedge clk); hi += filt_dom; end
      bus_dom = 1'b0;
      repeat (10) begin @(negedge clk); hi += filt_dom; end
      check("R2 pulse of filter width length", hi, FL);
      check("R2 no wake from spikes", wake_flag, 0);
   endtask

   task automatic t_basic();
      clean_start();
      pattern(PM, PM, PM);
      check("R1 minimal legal pattern wakes", wake_flag, 1);
   endtask

   task automatic t_glitch_inside();
      clean_start();
      hold(1'b1, 6); hold(1'b0, FL - 1); hold(1'b1, 6);
      hold(1'b0, 6); hold(1'b1, FL - 1); hold(1'b0, 6);
      hold(1'b1, PM);
      hold(1'b0, 20);
      check("R2 glitches inside phases ignored", wake_flag, 1);
   endtask

   task automatic t_short();
      clean_start();
      pattern(PM - 1, PM, PM);
      check("R3 short first dominant", wake_flag, 0);
      clean_start();
      pattern(PM, PM, PM - 1);
      check("R3 short second dominant", wake_flag, 0);
      clean_start();
      hold(1'b1, PM); hold(1'b0, PM - 1);
      pattern(PM, PM, PM);
      check("R3 short recessive restarts first phase", wake_flag, 1);
   endtask

   task automatic t_window();
      clean_start();
      pattern(15, 15, PM);
      check("R4 completes one cycle inside window", wake_flag, 1);
      clean_start();
      pattern(16, 15, PM);
      check("R4 completion at window limit loses", wake_flag, 0);
   endtask

   task automatic t_clamp();
      clean_start();
      hold(1'b1, 300);
      check("R7 clamped dominant no wake", wake_flag, 0);
      hold(1'b0, 20);
      check("R7 release of clamp no wake", wake_flag, 0);
   endtask

   task automatic t_abort();
      clean_start();
      hold(1'b1, PM); hold(1'b0, 5);
      abort_evt = 1'b1; @(negedge clk); abort_evt = 1'b0;
      hold(1'b0, 5); hold(1'b1, PM); hold(1'b0, 20);
      check("R5 abort discards partial pattern", wake_flag, 0);
   endtask

   task automatic t_standby();
      clean_start();
      stby_en = 1'b0;
      pattern(PM, PM, PM);
      check("R6 no detection out of standby", wake_flag, 0);
      clean_start();
      hold(1'b1, PM); hold(1'b0, 4);
      stby_en = 1'b0; @(negedge clk); stby_en = 1'b1;
      hold(1'b0, 6); hold(1'b1, PM); hold(1'b0, 20);
      check("R6 standby drop discards pattern", wake_flag, 0);
   endtask

   task automatic t_sticky();
      clean_start();
      pattern(PM, PM, PM);
      check("R8 wake set", wake_flag, 1);
      abort_evt = 1'b1; hold(1'b1, 50); abort_evt = 1'b0;
      hold(1'b0, 10);
      check("R8 flag survives bus and abort", wake_flag, 1);
      stby_en = 1'b0;
      @(negedge clk);
      check("R8 flag clears after standby drop", wake_flag, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_filter();
      t_basic();
      t_glitch_inside();
      t_short();
      t_window();
      t_clamp();
      t_abort();
      t_standby();
      t_sticky();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule